// File: doc/BRIEF.md
# Parallel EEPROM Page Write Sequencer

This host-side controller writes one page of a byte-wide parallel EEPROM. The host first fills a small local buffer with up to one page of bytes. It then gives a start address and a byte count. The sequencer runs the bus with active-low chip enable, output enable and write enable, an address bus and a bidirectional data bus. Every transaction opens with a fixed three-write unlock. The page bytes follow back to back. The controller then reads the last written address again and again until the device reports that its internal write has finished. At that point it pulses `done`.

Completion can be detected in two ways, chosen by a parameter. In the default mode, the controller waits until bit 7 of the polled byte equals bit 7 of the byte it wrote. In the toggle mode, it waits until bit 6 reads the same on two consecutive reads, with output enable taken high between the reads. A cycle-count timeout ends a poll that never completes and raises an error flag. All bus timing is counted in system clock cycles. When the controller is idle, the host can also request a single read of any address.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, and whenever `busy` is low, the bus is idle: `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high and the data bus is not driven.
- R2: Each accepted transaction first issues three writes, in this order: address 0x5555 with data 0xAA, address 0x2AAA with data 0x55, and address 0x5555 with data 0xA0. The page data writes follow. A transaction of N bytes makes exactly N+3 write strobes.
- R3: Byte i (0-based) of the transaction is buffer entry i. It is written to address {start_addr[14:6], (start_addr[5:0]+i) mod 64}, so the address wraps inside the 64-byte page.
- R4: `mem_oe_n` is high in every cycle in which `mem_we_n` is low.
- R5: The data bus is driven only during write cycles. It is released for at least one cycle before output enable falls for a read.
- R6: In bit-7 mode (TOGGLE_POLL=0), polling reads the last written address, and that address does not change while polling. The transaction completes on the first read whose bit 7 equals bit 7 of the last written byte.
- R7: In toggle mode (TOGGLE_POLL=1), the transaction completes when bit 6 is equal on two consecutive polling reads. Output enable goes high between any two reads.
- R8: If completion is not seen within TIMEOUT_CYC cycles of polling, `done` pulses together with `timeout_err` high. `timeout_err` stays high until the next transaction is accepted.
- R9: A `start` whose `byte_count` is 0 or greater than 64 is ignored: no bus activity occurs and `busy` stays low.
- R10: `start` and `rd_req` are ignored while `busy` is high.
- R11: An `rd_req` while idle performs one read of `rd_addr`. It then pulses `rd_valid` for one cycle with the byte read on `rd_data`.
- R12: `busy` rises in the cycle after a valid `start` is accepted. `done` is a one-cycle pulse, and `busy` is low in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_we | input | 1 | Write strobe for the page buffer |
| buf_waddr | input | 6 | Page buffer entry to write |
| buf_wdata | input | 8 | Byte to store in the page buffer |
| start | input | 1 | Request a page write transaction |
| start_addr | input | 15 | Address of the first page byte |
| byte_count | input | 7 | Number of bytes to write, 1 to 64 |
| rd_req | input | 1 | Request a single read while idle |
| rd_addr | input | 15 | Address for the single read |
| busy | output | 1 | A transaction or read is in progress |
| done | output | 1 | One-cycle pulse at the end of a write transaction |
| timeout_err | output | 1 | The last transaction timed out while polling |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds the read result |
| rd_data | output | 8 | Result of the single read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq | inout | 8 | Memory data bus |

## Verification
The bench builds two copies of the block, one with TOGGLE_POLL=0 and one with TOGGLE_POLL=1. Both use short strobe and gap counts (2, 3, 1, 3 and 2 cycles) and a 3000-cycle polling timeout. Each copy drives its own behavioural memory, which stays busy for 300 cycles after the last byte is loaded. With these values, full 64-byte pages and page-wrapping writes finish in a few thousand cycles. The timeout path is reached by holding a memory busy, and both completion detectors are exercised on the same stimulus.

// File: rtl/ewr_pkg.sv
package ewr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WSTB,
        ST_WHLD,
        ST_RGAP,
        ST_RSTB
    } ewr_state_e;

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  d;
    } ewr_cmd_t;

    localparam int UNLOCK_N = 3;

    function automatic ewr_cmd_t ewr_unlock_cmd(input logic [1:0] k);
        ewr_cmd_t c;
        case (k)
            2'd0:    c = '{a: 16'h5555, d: 8'hAA};
            2'd1:    c = '{a: 16'h2AAA, d: 8'h55};
            default: c = '{a: 16'h5555, d: 8'hA0};
        endcase
        return c;
    endfunction

    function automatic int ewr_max(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/ewr_page_buf.sv
module ewr_page_buf #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ewr_poll_timeout.sv
module ewr_poll_timeout #(
    parameter int LIMIT = 550000,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q >= CW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clear)                cnt_d = '0;
        else if (run && !expired) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ewr_poll_judge.sv
module ewr_poll_judge #(
    parameter bit TOGGLE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic load_bit,
    input  logic smp_valid,
    input  logic smp_bit,
    output logic finished
);
    logic ref_d, ref_q;
    logic armed_d, armed_q;

    assign finished = smp_valid && armed_q && (smp_bit == ref_q);

    generate
        if (TOGGLE) begin : g_toggle
            always_comb begin
                ref_d   = ref_q;
                armed_d = armed_q;
                if (clear) begin
                    ref_d   = load_bit;
                    armed_d = 1'b0;
                end else if (smp_valid) begin
                    ref_d   = smp_bit;
                    armed_d = 1'b1;
                end
            end
        end else begin : g_bit7
            always_comb begin
                ref_d   = ref_q;
                armed_d = armed_q;
                if (clear) begin
                    ref_d   = load_bit;
                    armed_d = 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            ref_q   <= ref_d;
            armed_q <= armed_d;
        end
    end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import ewr_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int PAGE_BYTES  = 64,
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 5,
    parameter int HOLD_CYC    = 2,
    parameter int RD_CYC      = 10,
    parameter int GAP_CYC     = 3,
    parameter int TIMEOUT_CYC = 550000,
    parameter bit TOGGLE_POLL = 1'b0,
    localparam int IDX_W = $clog2(PAGE_BYTES),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [IDX_W-1:0]  buf_waddr,
    input  logic [7:0]        buf_wdata,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [7:0]        mem_dq
);
    localparam int SEQ_W  = $clog2(PAGE_BYTES + UNLOCK_N);
    localparam int PH_MAX = ewr_max(ewr_max(SETUP_CYC, PULSE_CYC),
                                    ewr_max(ewr_max(HOLD_CYC, RD_CYC), GAP_CYC));
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int KEY    = TOGGLE_POLL ? 6 : 7;

    typedef struct packed {
        ewr_state_e        st;
        logic [PH_W-1:0]   ph;
        logic [SEQ_W-1:0]  seq;
        logic [SEQ_W-1:0]  last_seq;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdat;
        logic              host_rd;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_en;
        logic              done;
        logic              err;
        logic              rd_valid;
        logic [7:0]        rd_data;
    } regs_t;

    regs_t r_d, r_q;

    logic [SEQ_W-1:0]  nxt_seq;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]        tgt_data;
    logic [IDX_W-1:0]  buf_raddr;
    logic [7:0]        buf_rdata;
    logic              count_ok;
    logic              judge_clear;
    logic              smp_valid;
    logic              finished;
    logic              expired;
    logic              poll_active;
    logic              dq_drive;
    ewr_cmd_t          ucmd;

    ewr_page_buf #(.DEPTH(PAGE_BYTES)) buf_i (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    ewr_poll_timeout #(.LIMIT(TIMEOUT_CYC)) tmo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (judge_clear),
        .run     (poll_active),
        .expired (expired)
    );

    ewr_poll_judge #(.TOGGLE(TOGGLE_POLL)) judge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (judge_clear),
        .load_bit  (r_q.wdat[7]),
        .smp_valid (smp_valid),
        .smp_bit   (mem_dq[KEY]),
        .finished  (finished)
    );

    // Target of the next write in the sequence: unlock command or page byte.
    always_comb begin
        nxt_seq   = (r_q.st == ST_IDLE) ? '0 : r_q.seq + SEQ_W'(1);
        buf_raddr = IDX_W'(nxt_seq - SEQ_W'(UNLOCK_N));
        ucmd      = ewr_unlock_cmd(nxt_seq[1:0]);
        if (nxt_seq < SEQ_W'(UNLOCK_N)) begin
            tgt_addr = ADDR_W'(ucmd.a);
            tgt_data = ucmd.d;
        end else begin
            tgt_addr = {r_q.base[ADDR_W-1:IDX_W], r_q.base[IDX_W-1:0] + buf_raddr};
            tgt_data = buf_rdata;
        end
    end

    assign count_ok    = (byte_count != '0) && (byte_count <= CNT_W'(PAGE_BYTES));
    assign poll_active = ((r_q.st == ST_RGAP) || (r_q.st == ST_RSTB)) && !r_q.host_rd;

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.rd_valid = 1'b0;
        judge_clear  = 1'b0;
        smp_valid    = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (start && count_ok) begin
                    r_d.base     = start_addr;
                    r_d.last_seq = SEQ_W'(byte_count) + SEQ_W'(UNLOCK_N - 1);
                    r_d.seq      = '0;
                    r_d.addr     = tgt_addr;
                    r_d.wdat     = tgt_data;
                    r_d.err      = 1'b0;
                    r_d.host_rd  = 1'b0;
                    r_d.st       = ST_WSET;
                    r_d.ph       = PH_W'(SETUP_CYC - 1);
                end else if (rd_req) begin
                    r_d.addr    = rd_addr;
                    r_d.host_rd = 1'b1;
                    r_d.st      = ST_RGAP;
                    r_d.ph      = PH_W'(GAP_CYC - 1);
                end
            end
            ST_WSET: begin
                if (r_q.ph == '0) begin
                    r_d.st = ST_WSTB;
                    r_d.ph = PH_W'(PULSE_CYC - 1);
                end else begin
                    r_d.ph = r_q.ph - PH_W'(1);
                end
            end
            ST_WSTB: begin
                if (r_q.ph == '0) begin
                    r_d.st = ST_WHLD;
                    r_d.ph = PH_W'(HOLD_CYC - 1);
                end else begin
                    r_d.ph = r_q.ph - PH_W'(1);
                end
            end
            ST_WHLD: begin
                if (r_q.ph != '0) begin
                    r_d.ph = r_q.ph - PH_W'(1);
                end else if (r_q.seq == r_q.last_seq) begin
                    judge_clear = 1'b1;
                    r_d.st      = ST_RGAP;
                    r_d.ph      = PH_W'(GAP_CYC - 1);
                end else begin
                    r_d.seq  = nxt_seq;
                    r_d.addr = tgt_addr;
                    r_d.wdat = tgt_data;
                    r_d.st   = ST_WSET;
                    r_d.ph   = PH_W'(SETUP_CYC - 1);
                end
            end
            ST_RGAP: begin
                if (r_q.ph == '0) begin
                    r_d.st = ST_RSTB;
                    r_d.ph = PH_W'(RD_CYC - 1);
                end else begin
                    r_d.ph = r_q.ph - PH_W'(1);
                end
            end
            ST_RSTB: begin
                if (r_q.ph != '0) begin
                    r_d.ph = r_q.ph - PH_W'(1);
                end else if (r_q.host_rd) begin
                    r_d.rd_data  = mem_dq;
                    r_d.rd_valid = 1'b1;
                    r_d.host_rd  = 1'b0;
                    r_d.st       = ST_IDLE;
                end else begin
                    smp_valid = 1'b1;
                    if (finished) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.st = ST_RGAP;
                        r_d.ph = PH_W'(GAP_CYC - 1);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (poll_active && expired && !finished) begin
            r_d.done = 1'b1;
            r_d.err  = 1'b1;
            r_d.st   = ST_IDLE;
        end

        // Bus controls follow the next state so they change on clean edges.
        r_d.ce_n  = (r_d.st == ST_IDLE);
        r_d.we_n  = (r_d.st != ST_WSTB);
        r_d.oe_n  = (r_d.st != ST_RSTB);
        r_d.dq_en = (r_d.st == ST_WSET) || (r_d.st == ST_WSTB) || (r_d.st == ST_WHLD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.ce_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign dq_drive    = r_q.dq_en;
    assign mem_dq      = dq_drive ? r_q.wdat : 'z;
    assign mem_ce_n    = r_q.ce_n;
    assign mem_oe_n    = r_q.oe_n;
    assign mem_we_n    = r_q.we_n;
    assign mem_addr    = r_q.addr;
    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign timeout_err = r_q.err;
    assign rd_valid    = r_q.rd_valid;
    assign rd_data     = r_q.rd_data;
endmodule

// File: rtl/ewr_checker.sv
module ewr_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              timeout_err,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dq_drive,
    input logic              poll_active
);
    a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_oe_n && mem_we_n && !dq_drive));

    a_r4_oe_high_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    a_r5_no_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !dq_drive);

    a_r5_release_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(dq_drive));

    a_r6_poll_addr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_active && $past(poll_active)) |-> $stable(mem_addr));

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done);

    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind eeprom_page_writer ewr_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_addr    (mem_addr),
    .dq_drive    (dq_drive),
    .poll_active (poll_active)
);

// File: tb/eeprom_page_writer_tb_top.sv
module ewr_mem_model #(
    parameter int BUSY_CYC = 300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hang,
    input  logic        ce_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [14:0] addr,
    inout  wire  [7:0]  dq,
    output logic [31:0] n_writes,
    output logic [31:0] oe_viol,
    output logic        unlock_bad,
    output logic        poll_addr_bad,
    output logic [14:0] last_rd_addr,
    output logic        dev_busy
);
    logic [7:0]  mem [256];
    logic [14:0] log_a [70];
    logic [7:0]  log_d [70];
    logic [6:0]  lptr;
    logic [31:0] bcnt;
    logic        we_prev, oe_prev, tog, last_b7, busy_rd;
    logic [7:0]  rd_out;

    assign rd_out = dev_busy ? {~last_b7, tog, 6'b0} : mem[addr[7:0]];
    assign dq = (!ce_n && !oe_n && we_n) ? rd_out : 'z;

    always @(posedge clk) begin
        if (!rst_n) begin
            n_writes <= 0; oe_viol <= 0; unlock_bad <= 0; poll_addr_bad <= 0;
            last_rd_addr <= 0; dev_busy <= 0; lptr <= 0; bcnt <= 0;
            we_prev <= 1; oe_prev <= 1; tog <= 0; last_b7 <= 0; busy_rd <= 0;
        end else begin
            we_prev <= we_n;
            oe_prev <= oe_n;
            if (!we_n && !oe_n) oe_viol <= oe_viol + 1;
            if (!we_prev && we_n && !ce_n) begin
                log_a[lptr] <= addr;
                log_d[lptr] <= dq;
                lptr <= lptr + 1;
                n_writes <= n_writes + 1;
                last_b7 <= dq[7];
                dev_busy <= 1;
                bcnt <= BUSY_CYC;
            end else if (dev_busy && !hang) begin
                if (bcnt == 0) begin
                    if (lptr < 3 || log_a[0] != 15'h5555 || log_d[0] != 8'hAA ||
                        log_a[1] != 15'h2AAA || log_d[1] != 8'h55 ||
                        log_a[2] != 15'h5555 || log_d[2] != 8'hA0)
                        unlock_bad <= 1;
                    else
                        for (int k = 3; k < 70; k++)
                            if (k < int'(lptr)) mem[log_a[k][7:0]] <= log_d[k];
                    lptr <= 0;
                    dev_busy <= 0;
                    busy_rd <= 0;
                end else begin
                    bcnt <= bcnt - 1;
                end
            end
            if (oe_prev && !oe_n && !ce_n) begin
                if (dev_busy) begin
                    tog <= ~tog;
                    if (busy_rd && addr != last_rd_addr) poll_addr_bad <= 1;
                    busy_rd <= 1;
                end
                last_rd_addr <= addr;
            end
        end
    end
endmodule

module eeprom_page_writer_tb_top;
    localparam int TMO  = 3000;
    localparam int BUSY = 300;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        buf_we = 0;
    logic [5:0]  buf_waddr = 0;
    logic [7:0]  buf_wdata = 0;
    logic        start = 0;
    logic [14:0] start_addr = 0;
    logic [6:0]  byte_count = 0;
    logic        rd_req = 0;
    logic [14:0] rd_addr = 0;
    logic        hang = 0;

    logic        busy_a, done_a, err_a, rdv_a, ce_a, oe_a, we_a;
    logic        busy_b, done_b, err_b, rdv_b, ce_b, oe_b, we_b;
    logic [7:0]  rdd_a, rdd_b;
    logic [14:0] ad_a, ad_b;
    wire  [7:0]  dq_a, dq_b;
    logic [31:0] nw_a, nw_b, ov_a, ov_b;
    logic        ub_a, ub_b, pb_a, pb_b, mb_a, mb_b;
    logic [14:0] lr_a, lr_b;

    int total = 0, bad = 0;
    int done_cnt_a = 0, done_cnt_b = 0, rdv_cnt = 0;

    always #10 clk = ~clk;

    eeprom_page_writer #(.SETUP_CYC(2), .PULSE_CYC(3), .HOLD_CYC(1), .RD_CYC(3),
        .GAP_CYC(2), .TIMEOUT_CYC(TMO), .TOGGLE_POLL(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .rd_req(rd_req), .rd_addr(rd_addr),
        .busy(busy_a), .done(done_a), .timeout_err(err_a), .rd_valid(rdv_a),
        .rd_data(rdd_a), .mem_ce_n(ce_a), .mem_oe_n(oe_a), .mem_we_n(we_a),
        .mem_addr(ad_a), .mem_dq(dq_a));

    eeprom_page_writer #(.SETUP_CYC(2), .PULSE_CYC(3), .HOLD_CYC(1), .RD_CYC(3),
        .GAP_CYC(2), .TIMEOUT_CYC(TMO), .TOGGLE_POLL(1'b1)) dut_tg_i (
        .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_waddr(buf_waddr),
        .buf_wdata(buf_wdata), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .rd_req(rd_req), .rd_addr(rd_addr),
        .busy(busy_b), .done(done_b), .timeout_err(err_b), .rd_valid(rdv_b),
        .rd_data(rdd_b), .mem_ce_n(ce_b), .mem_oe_n(oe_b), .mem_we_n(we_b),
        .mem_addr(ad_b), .mem_dq(dq_b));

    ewr_mem_model #(.BUSY_CYC(BUSY)) mdl_a (
        .clk(clk), .rst_n(rst_n), .hang(hang), .ce_n(ce_a), .oe_n(oe_a),
        .we_n(we_a), .addr(ad_a), .dq(dq_a), .n_writes(nw_a), .oe_viol(ov_a),
        .unlock_bad(ub_a), .poll_addr_bad(pb_a), .last_rd_addr(lr_a), .dev_busy(mb_a));

    ewr_mem_model #(.BUSY_CYC(BUSY)) mdl_b (
        .clk(clk), .rst_n(rst_n), .hang(hang), .ce_n(ce_b), .oe_n(oe_b),
        .we_n(we_b), .addr(ad_b), .dq(dq_b), .n_writes(nw_b), .oe_viol(ov_b),
        .unlock_bad(ub_b), .poll_addr_bad(pb_b), .last_rd_addr(lr_b), .dev_busy(mb_b));

    always @(negedge clk) begin
        if (done_a) done_cnt_a <= done_cnt_a + 1;
        if (done_b) done_cnt_b <= done_cnt_b + 1;
        if (rdv_a)  rdv_cnt    <= rdv_cnt + 1;
    end

    // {start_addr[14:0], byte_count[6:0], seed[7:0]}
    localparam logic [29:0] VEC [4] = '{
        {15'h0040, 7'd1,  8'h3C},
        {15'h0081, 7'd5,  8'hF0},
        {15'h00C0, 7'd64, 8'h11},
        {15'h003A, 7'd10, 8'h80}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_buf(input int cnt, input logic [7:0] seed);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            buf_we = 1; buf_waddr = 6'(i); buf_wdata = seed + 8'(i);
        end
        @(negedge clk);
        buf_we = 0;
    endtask

    task automatic pulse_start(input logic [14:0] a, input logic [6:0] n);
        @(negedge clk);
        start = 1; start_addr = a; byte_count = n;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done(input int base_a, input int base_b, output int cyc);
        cyc = 0;
        while ((done_cnt_a <= base_a || done_cnt_b <= base_b) && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic host_read(input logic [14:0] a, input logic [7:0] exp, input string req);
        int base = rdv_cnt;
        int n = 0;
        @(negedge clk);
        rd_req = 1; rd_addr = a;
        @(negedge clk);
        rd_req = 0;
        while (!(rdv_a && rdv_b) && n < 100) begin @(negedge clk); n++; end
        chk(rdv_a && rdv_b, req, "rd_valid seen", rdv_a, 1);
        chk(rdd_a == exp, req, "rd_data bit7 unit", rdd_a, exp);
        chk(rdd_b == exp, req, "rd_data toggle unit", rdd_b, exp);
        @(negedge clk);
        chk(!rdv_a && rdv_cnt == base + 1, "R11", "rd_valid one cycle", rdv_cnt - base, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc, na, nb, da, db, errs;
        logic [14:0] wa;
        logic [7:0] ev;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ce_a && oe_a && we_a && !busy_a && !done_a, "R1", "bus idle a", {ce_a, oe_a, we_a, busy_a}, 4'b1110);
        chk(ce_b && oe_b && we_b && !busy_b && !done_b, "R1", "bus idle b", {ce_b, oe_b, we_b, busy_b}, 4'b1110);

        // Vector table: page writes through both completion detectors
        for (int v = 0; v < 4; v++) begin
            logic [14:0] sa;
            logic [6:0]  cnt;
            logic [7:0]  seed;
            {sa, cnt, seed} = VEC[v];
            load_buf(int'(cnt), seed);
            na = int'(nw_a); nb = int'(nw_b); da = done_cnt_a; db = done_cnt_b;
            pulse_start(sa, cnt);
            chk(busy_a && busy_b, "R12", "busy after start", busy_a, 1);
            wait_done(da, db, cyc);
            chk(done_cnt_a == da + 1, "R6", "bit7 poll completes", done_cnt_a - da, 1);
            chk(done_cnt_b == db + 1, "R7", "toggle poll completes", done_cnt_b - db, 1);
            chk(!err_a && !err_b, "R8", "no timeout", {err_a, err_b}, 0);
            chk(!ub_a && !ub_b, "R2", "unlock order", {ub_a, ub_b}, 0);
            chk(int'(nw_a) == na + int'(cnt) + 3 && int'(nw_b) == nb + int'(cnt) + 3,
                "R2", "strobe count", int'(nw_a) - na, int'(cnt) + 3);
            errs = 0;
            for (int i = 0; i < int'(cnt); i++) begin
                wa = {sa[14:6], sa[5:0] + 6'(i)};
                ev = seed + 8'(i);
                if (mdl_a.mem[wa[7:0]] != ev || mdl_b.mem[wa[7:0]] != ev) errs++;
            end
            chk(errs == 0, "R3", "page contents", errs, 0);
            wa = {sa[14:6], sa[5:0] + 6'(int'(cnt) - 1)};
            chk(lr_a == wa && lr_b == wa && !pb_a && !pb_b, "R6", "poll address", lr_a, wa);
            chk(ov_a == 0 && ov_b == 0, "R4", "oe high during we", ov_a, 0);
            chk(!busy_a && !busy_b && ce_a && ce_b, "R1", "idle after done", busy_a, 0);
            host_read(sa, seed, "R5");
        end

        // R9: invalid counts ignored
        na = int'(nw_a);
        pulse_start(15'h0200, 7'd0);
        repeat (20) @(negedge clk);
        chk(!busy_a && !busy_b && int'(nw_a) == na && ce_a, "R9", "count 0 ignored", busy_a, 0);
        pulse_start(15'h0200, 7'd65);
        repeat (20) @(negedge clk);
        chk(!busy_a && !busy_b && int'(nw_a) == na && ce_a, "R9", "count 65 ignored", busy_a, 0);

        // R10: start and rd_req while busy ignored
        load_buf(3, 8'h5A);
        na = int'(nw_a); da = done_cnt_a; db = done_cnt_b;
        pulse_start(15'h0100, 7'd3);
        repeat (10) @(negedge clk);
        rd_req = 1; rd_addr = 15'h0040;
        pulse_start(15'h0180, 7'd4);
        rd_req = 0;
        wait_done(da, db, cyc);
        repeat (20) @(negedge clk);
        chk(int'(nw_a) == na + 6, "R10", "start while busy ignored", int'(nw_a) - na, 6);
        chk(rdv_cnt == 4, "R10", "rd_req while busy ignored", rdv_cnt, 4);
        chk(done_cnt_a == da + 1 && done_cnt_b == db + 1, "R12", "one done per transaction",
            done_cnt_a - da, 1);
        chk(mdl_a.mem[8'h02] == 8'h5C, "R3", "short page last byte", mdl_a.mem[8'h02], 8'h5C);
        host_read(15'h0102, 8'h5C, "R11");

        // R8: timeout while the memory stays busy
        load_buf(2, 8'h01);
        hang = 1;
        da = done_cnt_a; db = done_cnt_b;
        pulse_start(15'h0010, 7'd2);
        wait_done(da, db, cyc);
        chk(err_a && err_b, "R8", "timeout flag", {err_a, err_b}, 2'b11);
        chk(cyc >= TMO, "R8", "timeout not early", cyc, TMO);
        hang = 0;
        repeat (600) @(negedge clk);
        chk(err_a && err_b, "R8", "flag held until next start", {err_a, err_b}, 2'b11);
        da = done_cnt_a; db = done_cnt_b;
        pulse_start(15'h0020, 7'd1);
        chk(!err_a && !err_b, "R8", "flag cleared at start", {err_a, err_b}, 0);
        wait_done(da, db, cyc);
        chk(!err_a && !err_b && mdl_a.mem[8'h20] == 8'h01, "R8", "clean after timeout",
            mdl_a.mem[8'h20], 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule